// File: doc/BRIEF.md
# Boot-Overlay Address Decoder

This block turns the 24-bit CPU address and bus strobes of a processor board into one-hot chip selects. The targets are:

- local RAM
- two ROM banks
- the serial/timer peripheral
- the board control latch
- an optional MMU window
- three cache-invalidate strobes
- two off-board bus windows: full 24-bit and short 16-bit addressing

Two inputs set the board build. One chooses between 128 KB and 512 KB of local RAM, which moves the point where the off-board 24-bit window begins. The other says whether the MMU is fitted.

After every reset the processor fetches its reset vector from the lowest eight bytes. Until four read cycles to that span have completed, those bytes select ROM bank 1 instead of RAM. After that the span belongs to RAM until the next reset. A read counts as completed on the cycle its address strobe is released.

Top module: `boot_addr_decoder`

## Requirements
- R1: While `as_i` is low, `sel_o` is all zero; this also holds during and straight after reset.
- R2: Addresses below the RAM top select RAM (`sel_o[0]`). The RAM top is 0x020000 with `big_ram_i`=0 and 0x080000 with `big_ram_i`=1.
- R3: Addresses from the RAM top up to 0xEFFFFF, and 0xFA0000–0xFEFFFF, select the off-board 24-bit window (`sel_o[9]`). Addresses 0xFF0000–0xFFFFFF select the off-board 16-bit window (`sel_o[10]`).
- R4: 0xF00000–0xF0FFFF selects ROM bank 1 (`sel_o[1]`). 0xF10000–0xF1FFFF selects ROM bank 2 (`sel_o[2]`).
- R5: 0xF20000–0xF3FFFF selects the peripheral (`sel_o[3]`) only when `lds_i` is high. With `lds_i` low nothing is selected there.
- R6: 0xF40000–0xF5FFFF selects the control latch (`sel_o[4]`).
- R7: 0xF60000–0xF7FFFF selects the MMU (`sel_o[5]`) when `mmu_present_i` is high. When it is low, nothing is selected there.
- R8: In 0xF80000–0xF9FFFF, address bits [2:1] choose the cache strobe: 1 gives bank-2 clear (`sel_o[6]`), 2 gives bank-1 clear (`sel_o[7]`), 3 gives clear-both (`sel_o[8]`), and 0 selects nothing.
- R9: At most one bit of `sel_o` is high in any cycle.
- R10: After reset, addresses 0x000000–0x000007 select ROM bank 1 instead of RAM until the fourth completed read in that span; they select RAM afterwards. Address 0x000008 is always decoded as RAM.
- R11: Only completed reads inside the boot span advance the overlay count. A read completes on the cycle `as_i` falls after being high with `rd_i`=1. Writes and reads elsewhere leave the count alone. Once the overlay has retired it stays retired until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, re-arms the boot overlay |
| as_i | input | 1 | Address strobe, high while a cycle is in progress |
| lds_i | input | 1 | Low (odd) byte lane strobe |
| rd_i | input | 1 | 1 for a read cycle, 0 for a write |
| addr_i | input | 24 | Byte address |
| big_ram_i | input | 1 | 1 selects the 512 KB RAM build |
| mmu_present_i | input | 1 | 1 when the MMU is fitted |
| sel_o | output | 11 | One-hot chip selects, bit positions as in the requirements |

## Verification
Two functions can fall in the same cycle: retiring the overlay, and decoding the next access to the boot span. The bench provokes this by releasing the strobe of the fourth boot read and then starting a new read at address 0 on the very next cycle. It expects RAM there, and ROM bank 1 on the access just before. Writes and out-of-span reads are placed between the counted reads. A reference model that keeps its own count judges every access, and a second reset confirms the overlay comes back.

// File: rtl/boot_dec_pkg.sv
package boot_dec_pkg;
  localparam int NSEL     = 11;
  localparam int S_RAM    = 0;
  localparam int S_ROM1   = 1;
  localparam int S_ROM2   = 2;
  localparam int S_PERIPH = 3;
  localparam int S_CTRL   = 4;
  localparam int S_MMU    = 5;
  localparam int S_CLR2   = 6;
  localparam int S_CLR1   = 7;
  localparam int S_CLRALL = 8;
  localparam int S_EXT24  = 9;
  localparam int S_EXT16  = 10;

  // RAM top in bytes for the selected build
  function automatic int ram_top_f(input logic big, input int small_b, input int large_b);
    return big ? large_b : small_b;
  endfunction

  // true when a byte address lies inside the reset-vector span
  function automatic logic in_span_f(input int addr, input int span);
    return addr < span;
  endfunction
endpackage

// File: rtl/boot_region_dec.sv
module boot_region_dec
  import boot_dec_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int SMALL_RAM = 32'h0002_0000,
  parameter int LARGE_RAM = 32'h0008_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              big_ram_i,
  input  logic              mmu_present_i,
  input  logic              lds_i,
  output logic [NSEL-1:0]   region_o
);
  localparam int PAGE_W = 8;

  logic [PAGE_W-1:0] page;
  logic              below_ram;

  assign page      = addr_i[ADDR_W-1 -: PAGE_W];
  assign below_ram = int'({1'b0, addr_i}) < ram_top_f(big_ram_i, SMALL_RAM, LARGE_RAM);

  always_comb begin
    region_o = '0;
    if (below_ram) begin
      region_o[S_RAM] = 1'b1;
    end else if (page < 8'hF0) begin
      region_o[S_EXT24] = 1'b1;
    end else begin
      case (page)
        8'hF0: region_o[S_ROM1] = 1'b1;
        8'hF1: region_o[S_ROM2] = 1'b1;
        8'hF2, 8'hF3: region_o[S_PERIPH] = lds_i;
        8'hF4, 8'hF5: region_o[S_CTRL] = 1'b1;
        8'hF6, 8'hF7: region_o[S_MMU] = mmu_present_i;
        8'hF8, 8'hF9: begin
          case (addr_i[2:1])
            2'd1:    region_o[S_CLR2]   = 1'b1;
            2'd2:    region_o[S_CLR1]   = 1'b1;
            2'd3:    region_o[S_CLRALL] = 1'b1;
            default: region_o = '0;
          endcase
        end
        8'hFF:   region_o[S_EXT16] = 1'b1;
        default: region_o[S_EXT24] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/boot_overlay.sv
module boot_overlay
  import boot_dec_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int BOOT_READS = 4,
  parameter int BOOT_SPAN  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              overlay_on,
  output logic              read_done
);
  localparam int CW = $clog2(BOOT_READS + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(BOOT_READS);

  logic          as_q, rd_q, span_q;
  logic [CW-1:0] done_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q   <= 1'b0;
      rd_q   <= 1'b0;
      span_q <= 1'b0;
    end else begin
      as_q <= as_i;
      if (as_i) begin
        rd_q   <= rd_i;
        span_q <= in_span_f(int'({1'b0, addr_i}), BOOT_SPAN);
      end
    end
  end

  // a read in the boot span finishes when the strobe drops
  assign read_done  = as_q && !as_i && rd_q && span_q;
  assign overlay_on = done_cnt < CNT_MAX;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_cnt <= '0;
    else if (read_done && overlay_on) done_cnt <= done_cnt + 1'b1;
  end

  a_r11_count_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !read_done |=> $stable(done_cnt));
  a_r11_retired_stays: assert property (@(posedge clk) disable iff (!rst_n)
    !overlay_on |=> !overlay_on);
endmodule

// File: rtl/boot_addr_decoder.sv
module boot_addr_decoder
  import boot_dec_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int SMALL_RAM  = 32'h0002_0000,
  parameter int LARGE_RAM  = 32'h0008_0000,
  parameter int BOOT_READS = 4,
  parameter int BOOT_SPAN  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_i,
  input  logic              lds_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              big_ram_i,
  input  logic              mmu_present_i,
  output logic [NSEL-1:0]   sel_o
);
  logic [NSEL-1:0] region;
  logic            overlay_on, read_done, span_hit;

  boot_region_dec #(.ADDR_W(ADDR_W), .SMALL_RAM(SMALL_RAM), .LARGE_RAM(LARGE_RAM)) u_region (
    .addr_i(addr_i), .big_ram_i(big_ram_i), .mmu_present_i(mmu_present_i),
    .lds_i(lds_i), .region_o(region));

  boot_overlay #(.ADDR_W(ADDR_W), .BOOT_READS(BOOT_READS), .BOOT_SPAN(BOOT_SPAN)) u_overlay (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .rd_i(rd_i), .addr_i(addr_i),
    .overlay_on(overlay_on), .read_done(read_done));

  assign span_hit = in_span_f(int'({1'b0, addr_i}), BOOT_SPAN);

  always_comb begin
    sel_o = '0;
    if (as_i) begin
      if (overlay_on && span_hit) sel_o[S_ROM1] = 1'b1;
      else sel_o = region;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !as_i |-> (sel_o == '0));
  a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));
  a_r5_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o[S_PERIPH] |-> lds_i);
  a_r10_rom_over_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (as_i && overlay_on && span_hit) |-> (sel_o[S_ROM1] && !sel_o[S_RAM]));
  a_r10_ram_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (as_i && !overlay_on && span_hit) |-> sel_o[S_RAM]);
  a_r11_done_needs_strobe_drop: assert property (@(posedge clk) disable iff (!rst_n)
    read_done |-> !as_i);
endmodule

// File: tb/boot_addr_decoder_tb.sv
module boot_addr_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        as_i = 1'b0, lds_i = 1'b0, rd_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic        big_ram_i = 1'b0, mmu_present_i = 1'b1;
  logic [10:0] sel_o;

  int checks = 0, errors = 0, reads_seen = 0;
  bit done = 0;

  always #4 clk = ~clk;

  boot_addr_decoder dut_i (.clk(clk), .rst_n(rst_n), .as_i(as_i), .lds_i(lds_i),
    .rd_i(rd_i), .addr_i(addr_i), .big_ram_i(big_ram_i),
    .mmu_present_i(mmu_present_i), .sel_o(sel_o));

  // behavioural reference: one expected select vector per access
  function automatic logic [10:0] model(int a, bit lds, bit big, bit mmu, int nreads);
    int top;
    logic [10:0] e;
    e = '0;
    top = big ? 'h80000 : 'h20000;
    if (a <= 7 && nreads < 4) e[1] = 1;
    else if (a < top) e[0] = 1;
    else if (a <= 'hEFFFFF) e[9] = 1;
    else if (a <= 'hF0FFFF) e[1] = 1;
    else if (a <= 'hF1FFFF) e[2] = 1;
    else if (a <= 'hF3FFFF) e[3] = lds;
    else if (a <= 'hF5FFFF) e[4] = 1;
    else if (a <= 'hF7FFFF) e[5] = mmu;
    else if (a <= 'hF9FFFF) begin
      if ((a / 2) % 4 == 1) e[6] = 1;
      else if ((a / 2) % 4 == 2) e[7] = 1;
      else if ((a / 2) % 4 == 3) e[8] = 1;
    end
    else if (a <= 'hFEFFFF) e[9] = 1;
    else e[10] = 1;
    return e;
  endfunction

  task automatic check(string req, logic [10:0] exp);
    checks++;
    if (sel_o !== exp) begin
      errors++;
      $display("FAIL %s: sel_o=%b expected=%b addr=%h", req, sel_o, exp, addr_i);
    end
  endtask

  task automatic access(string req, int a, bit rd, bit lds);
    @(negedge clk);
    addr_i = a[23:0]; rd_i = rd; lds_i = lds; as_i = 1'b1;
    #1 check(req, model(a, lds, big_ram_i, mmu_present_i, reads_seen));
    @(negedge clk);
    as_i = 1'b0;
    #1 check("R1", '0);
    if (rd && a <= 7) reads_seen++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; as_i = 1'b0;
    #1 check("R1", '0);
    as_i = 1'b1; addr_i = 24'h0; rd_i = 1'b1;
    #1 check("R10", 11'b000_0000_0010);
    as_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    reads_seen = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11: writes and out-of-span reads do not advance the overlay
    access("R11", 'h0, 0, 1);
    access("R11", 'h10, 1, 1);
    access("R10", 'h0, 1, 1);
    access("R10", 'h2, 1, 1);
    access("R11", 'h6, 0, 0);
    access("R10", 'h4, 1, 1);
    access("R10", 'h8, 1, 1);
    access("R10", 'h6, 1, 1);   // fourth counted read, still ROM
    access("R10", 'h0, 1, 1);   // first access after retirement: RAM
    access("R11", 'h2, 1, 1);
    access("R11", 'h4, 0, 1);
    // address map, small RAM build with MMU
    access("R2", 'h1FFFE, 1, 1);
    access("R3", 'h20000, 1, 1);
    access("R3", 'hEFFFFF, 1, 1);
    access("R4", 'hF00000, 1, 1);
    access("R4", 'hF0FFFE, 1, 1);
    access("R4", 'hF10000, 1, 1);
    access("R5", 'hF20001, 1, 1);
    access("R5", 'hF3FFFF, 0, 1);
    access("R5", 'hF20000, 1, 0);
    access("R6", 'hF40000, 0, 1);
    access("R6", 'hF5FFFE, 1, 1);
    access("R7", 'hF60000, 1, 1);
    access("R7", 'hF7FFFE, 1, 1);
    access("R8", 'hF80002, 0, 1);
    access("R8", 'hF80004, 0, 1);
    access("R8", 'hF80006, 0, 1);
    access("R8", 'hF80000, 0, 1);
    access("R8", 'hF9FFFA, 0, 1);
    access("R3", 'hFA0000, 1, 1);
    access("R3", 'hFEFFFF, 1, 1);
    access("R3", 'hFF0000, 1, 1);
    access("R3", 'hFFFFFF, 1, 1);
    mmu_present_i = 1'b0;
    access("R7", 'hF60000, 1, 1);
    access("R9", 'hF70010, 0, 1);
    big_ram_i = 1'b1;
    access("R2", 'h20000, 1, 1);
    access("R2", 'h7FFFE, 1, 1);
    access("R3", 'h80000, 1, 1);
    // R10: second reset re-arms the overlay
    do_reset();
    access("R10", 'h4, 1, 1);
    access("R2", 'h40000, 1, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule